// File: doc/BRIEF.md
# Parallel-Lane Ramp Pattern Injector

This block sits in a sample path that carries several samples per data clock, packed side by side into one parallel word. It can substitute a fixed test ramp for the live samples. Each output word is either the input word delayed by one data clock, or a ramp in which lane 0 holds a programmed start value and each higher lane holds one more than the lane below it. The ramp does not continue from one word to the next. It starts again at the start value on every data clock, so while the settings stay the same every ramp word is identical. There is no valid strobe, and the block produces a word on every data clock.

The start value and the on/off switch are written by a host on a separate register clock. A one-cycle load pulse presents a 32-bit start value and an enable bit together. The pair is carried into the data clock domain by a toggle handshake. The data side adopts the start value and the enable as one unit, so no output word ever mixes old and new settings. Both domains use synchronous active-low resets, which are expected to be asserted together.

Top module: `ramp_injector`

## Requirements
- R1: While the data reset is asserted, `dout` is all zeros. After reset the pattern is off, so the block passes samples through.
- R2: With the pattern off, `dout` in each data cycle equals `din` from the previous data cycle. Latency is exactly one data clock.
- R3: With the pattern on, lane k of `dout` (bits k*S to k*S+S-1) equals start + k, and lane 0 equals the start value.
- R4: With the pattern on, `din` has no effect: every output word is the same ramp word.
- R5: Lane values wrap modulo 2^S. A start value of 2^S-4 with 8 lanes gives 2^S-4, 2^S-3, 2^S-2, 2^S-1, 0, 1, 2, 3.
- R6: Only bits S-1:0 of the 32-bit `host_base` are used. The upper bits have no effect on the output.
- R7: A setting loaded with `host_load` appears at `dout` within 24 data clocks, with a 50 MHz data clock and a register clock of about 33 MHz.
- R8: While the pattern is being switched on or off, every output word is either a complete ramp word or the complete pass-through word. No cycle is dropped or repeated.
- R9: When loads arrive while an earlier transfer is still in flight, the setting from the last load is the one that takes effect. A value in flight stays stable until the data side acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register (host) clock |
| reg_rst_n | input | 1 | Synchronous active-low reset, register domain |
| host_load | input | 1 | One-cycle pulse that loads `host_base` and `host_en` |
| host_en | input | 1 | Pattern enable presented with the load |
| host_base | input | 32 | Ramp start value; bits S-1:0 are used |
| dat_clk | input | 1 | Data clock |
| dat_rst_n | input | 1 | Synchronous active-low reset, data domain |
| din | input | P*S | Incoming parallel word, lane k at bits k*S+S-1:k*S |
| dout | output | P*S | Registered outgoing parallel word |

## Verification
Pass-through is driven with a fresh pseudo-random word on every cycle, so a wrong latency or a swapped lane shows up at once. The ramp is checked against the same changing input, which shows that the input is ignored. It is checked with a mid-range start value and with a start value near the top of the range that also has nonzero upper host bits; the second case separates correct wrap and truncation from carries leaking out of a lane. Enable, disable and back-to-back loads are checked with the rule that each word is either a whole ramp or the whole input word, followed by an exact check of the final setting, which separates a coherent hand-over from a torn or lost one.

// File: rtl/ramp_pkg.sv
// ramp_pkg: shared constants for the ramp injector.
// Assumes the host register word is 32 bits wide.
package ramp_pkg;
    localparam int HOST_W      = 32;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ramp_sync_bit.sv
// ramp_sync_bit: multi-flop synchronizer for a single level or toggle signal.
// Assumes the input changes no faster than the destination clock can sample it.
module ramp_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ramp_cfg_sender.sv
// ramp_cfg_sender: register-domain half of the settings handshake.
// Keeps the host's latest load in a staging pair and launches it as a stable
// transfer pair with a request toggle. A load that arrives while a transfer is
// in flight waits in staging and is sent after the acknowledge returns.
// Assumes ack_tgl is the data side's acknowledge toggle, not yet synchronized.
module ramp_cfg_sender
    import ramp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              en_in,
    input  logic [HOST_W-1:0] base_in,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output logic              xfer_en,
    output logic [HOST_W-1:0] xfer_base,
    output logic              busy
);
    logic              stage_en;
    logic [HOST_W-1:0] stage_base;
    logic              pend;
    logic              ack_s;
    logic              launch;

    ramp_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign busy   = (req_tgl != ack_s);
    assign launch = pend && !busy;

    // capture the newest host load into the staging pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_en   <= 1'b0;
            stage_base <= '0;
        end else if (load) begin
            stage_en   <= en_in;
            stage_base <= base_in;
        end
    end

    // track whether staging holds a pair that has not been sent
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (load)   pend <= 1'b1;
        else if (launch) pend <= 1'b0;
    end

    // launch staging into the transfer pair and flip the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_en   <= 1'b0;
            xfer_base <= '0;
            req_tgl   <= 1'b0;
        end else if (launch) begin
            xfer_en   <= stage_en;
            xfer_base <= stage_base;
            req_tgl   <= ~req_tgl;
        end
    end
endmodule

// File: rtl/ramp_cfg_receiver.sv
// ramp_cfg_receiver: data-domain half of the settings handshake.
// Detects a request toggle and adopts the transfer pair as one unit.
// Assumes xfer_en and xfer_base are held stable until ack_tgl is returned.
module ramp_cfg_receiver
    import ramp_pkg::*;
#(
    parameter int S = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic              xfer_en,
    input  logic [HOST_W-1:0] xfer_base,
    output logic              ack_tgl,
    output logic              act_en,
    output logic [S-1:0]      act_base
);
    logic req_s;
    logic new_req;

    ramp_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    assign new_req = (req_s != ack_tgl);

    // adopt the enable and the truncated start value together, then acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en   <= 1'b0;
            act_base <= '0;
            ack_tgl  <= 1'b0;
        end else if (new_req) begin
            act_en   <= xfer_en;
            act_base <= xfer_base[S-1:0];
            ack_tgl  <= req_s;
        end
    end
endmodule

// File: rtl/ramp_lane_gen.sv
// ramp_lane_gen: per-lane output register choosing ramp or pass-through.
// Lane k takes base+k (modulo 2^S) when en is set, else the input lane.
// Assumes en and base change only at word boundaries (they are registers).
module ramp_lane_gen #(
    parameter int S = 16,
    parameter int P = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [S-1:0] base,
    input  logic [P*S-1:0] din,
    output logic [P*S-1:0] dout
);
    for (genvar k = 0; k < P; k++) begin : g_lane
        logic [S-1:0] ramp_val;
        logic [S-1:0] lane_q;

        assign ramp_val = base + S'(k);

        // register one lane: ramp value or live sample
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= en ? ramp_val : din[k*S +: S];
        end

        assign dout[k*S +: S] = lane_q;
    end
endmodule

// File: rtl/ramp_injector.sv
// ramp_injector: top level. Crosses host settings into the data clock and
// either passes each parallel word through or replaces it with a ramp that
// restarts every word. Assumes both resets are asserted together.
module ramp_injector
    import ramp_pkg::*;
#(
    parameter int S = 16,
    parameter int P = 8
) (
    input  logic              reg_clk,
    input  logic              reg_rst_n,
    input  logic              host_load,
    input  logic              host_en,
    input  logic [HOST_W-1:0] host_base,
    input  logic              dat_clk,
    input  logic              dat_rst_n,
    input  logic [P*S-1:0]    din,
    output logic [P*S-1:0]    dout
);
    logic              req_tgl;
    logic              ack_tgl;
    logic              xfer_en;
    logic [HOST_W-1:0] xfer_base;
    logic              busy;
    logic              act_en;
    logic [S-1:0]      act_base;

    ramp_cfg_sender u_send (
        .clk       (reg_clk),
        .rst_n     (reg_rst_n),
        .load      (host_load),
        .en_in     (host_en),
        .base_in   (host_base),
        .ack_tgl   (ack_tgl),
        .req_tgl   (req_tgl),
        .xfer_en   (xfer_en),
        .xfer_base (xfer_base),
        .busy      (busy)
    );

    ramp_cfg_receiver #(.S(S)) u_recv (
        .clk       (dat_clk),
        .rst_n     (dat_rst_n),
        .req_tgl   (req_tgl),
        .xfer_en   (xfer_en),
        .xfer_base (xfer_base),
        .ack_tgl   (ack_tgl),
        .act_en    (act_en),
        .act_base  (act_base)
    );

    ramp_lane_gen #(.S(S), .P(P)) u_lanes (
        .clk   (dat_clk),
        .rst_n (dat_rst_n),
        .en    (act_en),
        .base  (act_base),
        .din   (din),
        .dout  (dout)
    );
endmodule

// File: rtl/ramp_injector_chk.sv
// ramp_injector_chk: assertion checker bound to ramp_injector.
// Observes the ports plus the adopted settings and the transfer pair.
module ramp_injector_chk #(
    parameter int S = 16,
    parameter int P = 8
) (
    input logic           reg_clk,
    input logic           reg_rst_n,
    input logic           dat_clk,
    input logic           dat_rst_n,
    input logic [P*S-1:0] din,
    input logic [P*S-1:0] dout,
    input logic           act_en,
    input logic [S-1:0]   act_base,
    input logic           busy,
    input logic           xfer_en,
    input logic [31:0]    xfer_base
);
    logic [P*S-1:0] exp_ramp;
    logic           out_is_ramp;

    // model word for the currently adopted start value, and ramp shape of dout
    always_comb begin
        out_is_ramp = 1'b1;
        for (int k = 0; k < P; k++) begin
            exp_ramp[k*S +: S] = act_base + S'(k);
            if (dout[k*S +: S] != dout[S-1:0] + S'(k)) out_is_ramp = 1'b0;
        end
    end

    // R1
    reset_off_chk: assert property (@(posedge dat_clk) disable iff (!dat_rst_n)
        $rose(dat_rst_n) |-> !act_en);

    // R2
    pass_latency_chk: assert property (@(posedge dat_clk) disable iff (!dat_rst_n)
        !act_en |=> dout == $past(din));

    // R3
    ramp_value_chk: assert property (@(posedge dat_clk) disable iff (!dat_rst_n)
        act_en |=> dout == $past(exp_ramp));

    // R8
    whole_word_chk: assert property (@(posedge dat_clk) disable iff (!dat_rst_n)
        $past(dat_rst_n) |-> (out_is_ramp || dout == $past(din)));

    // R9
    xfer_hold_chk: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        (busy && $past(busy)) |-> ($stable(xfer_base) && $stable(xfer_en)));
endmodule

bind ramp_injector ramp_injector_chk #(.S(S), .P(P)) u_chk (
    .reg_clk   (reg_clk),
    .reg_rst_n (reg_rst_n),
    .dat_clk   (dat_clk),
    .dat_rst_n (dat_rst_n),
    .din       (din),
    .dout      (dout),
    .act_en    (act_en),
    .act_base  (act_base),
    .busy      (busy),
    .xfer_en   (xfer_en),
    .xfer_base (xfer_base)
);

// File: tb/ramp_injector_tb.sv
// ramp_injector_tb: scoreboard bench. A driver pushes one expectation per
// input word; a monitor pops and compares one data clock later.
module ramp_injector_tb;
    localparam int S = 16;
    localparam int P = 8;
    localparam int W = P * S;

    typedef enum int {K_SKIP, K_PASS, K_RAMP, K_EITHER} kind_t;
    typedef struct {
        kind_t        kind;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic          reg_clk = 1'b0;
    logic          reg_rst_n = 1'b0;
    logic          host_load = 1'b0;
    logic          host_en = 1'b0;
    logic [31:0]   host_base = '0;
    logic          dat_clk = 1'b0;
    logic          dat_rst_n = 1'b0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;

    item_t  sb_q[$];
    kind_t  mode = K_SKIP;
    logic [S-1:0] mode_base = '0;
    string  mode_tag = "";
    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;

    ramp_injector #(.S(S), .P(P)) u_dut (
        .reg_clk   (reg_clk),
        .reg_rst_n (reg_rst_n),
        .host_load (host_load),
        .host_en   (host_en),
        .host_base (host_base),
        .dat_clk   (dat_clk),
        .dat_rst_n (dat_rst_n),
        .din       (din),
        .dout      (dout)
    );

    always #10 dat_clk = ~dat_clk;   // 50 MHz
    always #15 reg_clk = ~reg_clk;   // about 33 MHz

    function automatic logic [W-1:0] ramp_word(input logic [S-1:0] b);
        logic [W-1:0] w;
        for (int k = 0; k < P; k++) w[k*S +: S] = b + S'(k);
        return w;
    endfunction

    function automatic bit is_ramp(input logic [W-1:0] w);
        for (int k = 0; k < P; k++)
            if (w[k*S +: S] != w[S-1:0] + S'(k)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: new input word every data cycle, expectation pushed to scoreboard
    initial begin
        forever begin
            @(negedge dat_clk);
            #1;
            if (dat_rst_n) begin
                item_t it;
                for (int k = 0; k < W / 32; k++) din[k*32 +: 32] = $urandom;
                it.kind = mode;
                it.tag  = mode_tag;
                it.exp  = (mode == K_RAMP) ? ramp_word(mode_base) : din;
                sb_q.push_back(it);
            end
        end
    end

    // monitor: compare the word produced from the previous cycle's input
    initial begin
        forever begin
            @(negedge dat_clk);
            if (sb_q.size() > 0 && !done) begin
                item_t it;
                it = sb_q.pop_front();
                case (it.kind)
                    K_PASS, K_RAMP: check(dout == it.exp, it.tag, dout, it.exp);
                    K_EITHER: check(dout == it.exp || is_ramp(dout), it.tag, dout, it.exp);
                    default: ;
                endcase
            end
        end
    end

    task automatic host_write(input logic [31:0] b, input logic e);
        @(negedge reg_clk);
        host_base = b;
        host_en   = e;
        host_load = 1'b1;
        @(negedge reg_clk);
        host_load = 1'b0;
    endtask

    task automatic run(input kind_t k, input logic [S-1:0] b, input string t, input int n);
        mode      = k;
        mode_base = b;
        mode_tag  = t;
        repeat (n) @(negedge dat_clk);
    endtask

    // watchdog
    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // main sequence
    initial begin
        repeat (4) @(negedge dat_clk);
        // R1: output cleared during reset
        check(dout == '0, "R1 reset", dout, '0);
        @(negedge dat_clk);
        reg_rst_n = 1'b1;
        dat_rst_n = 1'b1;
        // R1 R2: pass-through by default with one-cycle latency
        run(K_PASS, '0, "R1 R2 pass-through after reset", 20);
        // R7 R8: switch on, each transition word whole, then exact
        fork
            host_write(32'd1000, 1'b1);
            run(K_EITHER, '0, "R8 enable transition", 24);
        join
        // R3 R4 R7: ramp 1000..1007 every word despite changing input
        run(K_RAMP, S'(1000), "R3 R4 R7 ramp base 1000", 30);
        // R5 R6: wrap and upper host bits ignored
        fork
            host_write(32'h1234_FFFC, 1'b1);
            run(K_EITHER, '0, "R8 base change transition", 24);
        join
        run(K_RAMP, S'(16'hFFFC), "R5 R6 wrap and truncation", 30);
        // R8: switch off, back to pass-through
        fork
            host_write(32'd5, 1'b0);
            run(K_EITHER, '0, "R8 disable transition", 24);
        join
        run(K_PASS, '0, "R8 pass-through after disable", 20);
        // R9: back-to-back loads, last one wins
        fork
            begin
                host_write(32'd50, 1'b1);
                host_write(32'd77, 1'b1);
            end
            run(K_EITHER, '0, "R9 back-to-back transition", 40);
        join
        run(K_RAMP, S'(77), "R9 last load applied", 30);
        run(K_SKIP, '0, "", 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule